// File: doc/BRIEF.md
# Character Cell Row Counter

This block tracks which pixel row inside a text character cell the raster is currently drawing. It holds a small up-counter that advances by one at the start of each display line that shows part of the character matrix. When the counter sits on the final row of a cell and the next line begins, the counter returns to zero instead of advancing. At that same moment the block emits a one-cycle wrap strobe, which a neighbouring block uses to move on to the next character row.

A height-select input picks between normal cells of 8 rows and tall cells of 16 rows at run time. The final-row detect is purely combinational and is never held. It therefore follows the height-select input and the count as they are at the start-of-line pulse. Lines outside the character matrix leave the count untouched, but they do not suppress a wrap.

Top module: `cell_row_counter`

## Requirements
- R1: A synchronous active-high `rst` clears `rowCount` to 0 on the next clock edge, from any state.
- R2: `lastRow` is combinational and is high exactly when the low three bits of `rowCount` are all ones and either bit 3 is one or `tallCell` is 0. So it is high at count 7 or 15 with `tallCell`=0, and only at count 15 with `tallCell`=1.
- R3: `cellWrap` is high in the same cycle whenever `lineStart` and `lastRow` are both high, and is low otherwise.
- R4: In a cycle with `cellWrap` high, `rowCount` becomes 0 on the next edge, whatever the value of `offMatrix`.
- R5: In a cycle with `lineStart` high, `offMatrix` low and `cellWrap` low, `rowCount` increases by one on the next edge.
- R6: In a cycle with `lineStart` high, `offMatrix` high and `cellWrap` low, `rowCount` keeps its value.
- R7: In a cycle with `lineStart` low, `rowCount` keeps its value.
- R8: If `tallCell` rises from 0 to 1 while the count is 7 and before the next `lineStart`, then `lastRow` drops, no wrap occurs, and the next matrix line moves the count to 8.
- R9: If `tallCell` falls to 0 while the count is between 8 and 14, the counter keeps advancing, and the wrap happens only at count 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lineStart | input | 1 | One-cycle pulse at the start of each raster line |
| offMatrix | input | 1 | High when the current line shows no character matrix |
| tallCell | input | 1 | 1 selects 16-row cells, 0 selects 8-row cells |
| rowCount | output | 4 | Current pixel row inside the character cell |
| lastRow | output | 1 | Count is on the final row for the current height selection |
| cellWrap | output | 1 | One-cycle strobe: the counter returns to zero at this line start |

## Verification
The counter is stepped through full cells in normal height, tall height and a mix of matrix and off-matrix lines. Comparing these runs separates the increment path from the hold path, and shows that a wrap on an off-matrix line still clears the count. Idle cycles between line pulses expose any advance that is not gated by the line pulse. Two height-switch sequences show that the final-row detect is unlatched: raising the height select at count 7 must cancel the wrap, while dropping it at count 9 must carry the count on to 15. A mid-cell reset confirms that the synchronous clear takes priority over counting.

// File: rtl/crc_pkg.sv
package crc_pkg;
  // Width of the row counter and width of the short-cell row field.
  localparam int unsigned CountW = 4;
  localparam int unsigned ShortW = 3;

  // Strobes the control sends to the datapath each cycle.
  typedef struct packed {
    logic clear;    // return the count to zero
    logic advance;  // add one to the count
  } crcStrobes_t;
endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_pkg::*;
(
  input  logic        lineStart,
  input  logic        offMatrix,
  input  logic        lastRow,
  output crcStrobes_t strobes
);
  logic wrapNow;

  // A wrap needs both the final-row detect and a new line; nothing is held.
  assign wrapNow = lineStart & lastRow;

  always_comb begin
    strobes.clear   = wrapNow;
    strobes.advance = lineStart & ~offMatrix & ~wrapNow;
  end
endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_pkg::*;
#(
  parameter int unsigned CNT_W   = CountW,
  parameter int unsigned SHORT_W = ShortW
) (
  input  logic             clk,
  input  logic             rst,
  input  crcStrobes_t      strobes,
  input  logic             tallCell,
  output logic [CNT_W-1:0] count,
  output logic             lastRow
);
  localparam int unsigned HighW = CNT_W - SHORT_W;

  logic [CNT_W-1:0] countQ;
  logic             lowFull;
  logic             highFull;

  always_ff @(posedge clk) begin
    if (rst) begin
      countQ <= '0;
    end else if (strobes.clear) begin
      countQ <= '0;
    end else if (strobes.advance) begin
      countQ <= countQ + CNT_W'(1);
    end
  end

  // Short-cell rows all ones in the low field; tall cells also need the high field full.
  assign lowFull = &countQ[SHORT_W-1:0];

  generate
    if (HighW > 0) begin : g_high
      assign highFull = &countQ[CNT_W-1:SHORT_W];
    end else begin : g_nohigh
      assign highFull = 1'b1;
    end
  endgenerate

  assign lastRow = lowFull & (highFull | ~tallCell);
  assign count   = countQ;
endmodule

// File: rtl/cell_row_counter.sv
module cell_row_counter
  import crc_pkg::*;
#(
  parameter int unsigned CNT_W   = CountW,
  parameter int unsigned SHORT_W = ShortW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lineStart,
  input  logic             offMatrix,
  input  logic             tallCell,
  output logic [CNT_W-1:0] rowCount,
  output logic             lastRow,
  output logic             cellWrap
);
  crcStrobes_t strobes;
  logic        lastRowInt;

  crc_ctrl ctrl_i (
    .lineStart (lineStart),
    .offMatrix (offMatrix),
    .lastRow   (lastRowInt),
    .strobes   (strobes)
  );

  crc_datapath #(
    .CNT_W   (CNT_W),
    .SHORT_W (SHORT_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .tallCell (tallCell),
    .count    (rowCount),
    .lastRow  (lastRowInt)
  );

  assign lastRow  = lastRowInt;
  assign cellWrap = strobes.clear;
endmodule

// File: rtl/cell_row_counter_chk.sv
module cell_row_counter_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             lineStart,
  input logic             offMatrix,
  input logic             tallCell,
  input logic [CNT_W-1:0] rowCount,
  input logic             lastRow,
  input logic             cellWrap
);
  // R1: reset clears the count
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> rowCount == '0);

  // R2: the final-row flag implies a full low field; a fully set count is always final
  assert_last_low_full_R2: assert property (@(posedge clk) disable iff (rst)
    lastRow |-> (&rowCount[2:0]));
  assert_full_is_last_R2: assert property (@(posedge clk) disable iff (rst)
    (&rowCount) |-> lastRow);

  // R3: a wrap only happens at a line start on the final row
  assert_wrap_needs_line_R3: assert property (@(posedge clk) disable iff (rst)
    cellWrap |-> (lineStart && lastRow));

  // R4: a wrap clears the count
  assert_wrap_clears_R4: assert property (@(posedge clk) disable iff (rst)
    cellWrap |=> rowCount == '0);

  // R5: a matrix line start advances the count
  assert_matrix_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (lineStart && !offMatrix && !cellWrap) |=> rowCount == CNT_W'($past(rowCount) + 1'b1));

  // R6: an off-matrix line start without a wrap holds the count
  assert_offmatrix_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (lineStart && offMatrix && !cellWrap) |=> $stable(rowCount));

  // R7: no line start, no change
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !lineStart |=> $stable(rowCount));

  // R8: tall cells never flag the final row below the top count
  assert_tall_no_early_R8: assert property (@(posedge clk) disable iff (rst)
    (tallCell && !(&rowCount)) |-> !lastRow);
endmodule

bind cell_row_counter cell_row_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .lineStart (lineStart),
  .offMatrix (offMatrix),
  .tallCell  (tallCell),
  .rowCount  (rowCount),
  .lastRow   (lastRow),
  .cellWrap  (cellWrap)
);

// File: tb/cell_row_counter_tb_top.sv
`timescale 1ns/1ps
module cell_row_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lineStart = 1'b0;
  logic       offMatrix = 1'b0;
  logic       tallCell = 1'b0;
  logic [3:0] rowCount;
  logic       lastRow;
  logic       cellWrap;

  int checks = 0;
  int errors = 0;
  int expCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cell_row_counter dut_i (
    .clk       (clk),
    .rst       (rst),
    .lineStart (lineStart),
    .offMatrix (offMatrix),
    .tallCell  (tallCell),
    .rowCount  (rowCount),
    .lastRow   (lastRow),
    .cellWrap  (cellWrap)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Final-row rule as stated in R2.
  function automatic bit expLast(input int c, input bit tall);
    return ((c % 8) == 7) && ((c >= 8) || !tall);
  endfunction

  // One line-start pulse; checks the same-cycle flags and the count after the edge.
  task automatic doLine(input bit off, input string tag);
    bit wrapExp;
    @(negedge clk);
    lineStart = 1'b1;
    offMatrix = off;
    #1;
    wrapExp = expLast(expCnt, tallCell);
    check({tag, " R3 wrap"}, int'(cellWrap), int'(wrapExp));
    @(negedge clk);
    lineStart = 1'b0;
    offMatrix = 1'b0;
    if (wrapExp) expCnt = 0;
    else if (!off) expCnt = expCnt + 1;
    #1;
    check({tag, wrapExp ? " R4 count" : (off ? " R6 count" : " R5 count")},
          int'(rowCount), expCnt);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expCnt = 0;
    #1;
    check("R1 count after reset", int'(rowCount), 0);
    check("R1 wrap after reset", int'(cellWrap), 0);
  endtask

  task automatic testResetState();
    #1;
    check("R1 initial count", int'(rowCount), 0);
    check("R2 initial last", int'(lastRow), 0);
  endtask

  task automatic testShortCell();
    tallCell = 1'b0;
    for (int i = 0; i < 7; i++) doLine(1'b0, "short");
    #1;
    check("R2 last at 7 short", int'(lastRow), 1);
    doLine(1'b0, "short wrap");
    check("R2 last cleared", int'(lastRow), 0);
  endtask

  task automatic testIdle();
    doLine(1'b0, "idle prep");
    doLine(1'b0, "idle prep");
    repeat (6) @(negedge clk);
    #1;
    check("R7 idle hold", int'(rowCount), expCnt);
  endtask

  task automatic testOffMatrix();
    doLine(1'b1, "off hold");
    doLine(1'b1, "off hold");
    while (expCnt != 7) doLine(1'b0, "off climb");
    doLine(1'b1, "off wrap");
    check("R4 wrap on off line", int'(rowCount), 0);
  endtask

  task automatic testTallCell();
    tallCell = 1'b1;
    for (int i = 0; i < 7; i++) doLine(1'b0, "tall");
    #1;
    check("R2 no last at 7 tall", int'(lastRow), 0);
    for (int i = 0; i < 8; i++) doLine(1'b0, "tall");
    #1;
    check("R2 last at 15 tall", int'(lastRow), 1);
    doLine(1'b0, "tall wrap");
    check("R4 tall wrap count", int'(rowCount), 0);
  endtask

  task automatic testRaiseTall();
    @(negedge clk);
    tallCell = 1'b0;
    for (int i = 0; i < 7; i++) doLine(1'b0, "raise");
    #1;
    check("R8 last at 7", int'(lastRow), 1);
    @(negedge clk);
    tallCell = 1'b1;
    #1;
    check("R8 last dropped", int'(lastRow), 0);
    doLine(1'b0, "raise R8");
    check("R8 moved to 8", int'(rowCount), 8);
    doReset();
  endtask

  task automatic testDropTall();
    @(negedge clk);
    tallCell = 1'b1;
    for (int i = 0; i < 9; i++) doLine(1'b0, "drop");
    @(negedge clk);
    tallCell = 1'b0;
    #1;
    check("R9 no last at 9", int'(lastRow), 0);
    while (expCnt != 15) doLine(1'b0, "drop R9");
    #1;
    check("R9 last at 15", int'(lastRow), 1);
    doLine(1'b0, "drop R9 wrap");
    check("R9 wrap to 0", int'(rowCount), 0);
  endtask

  task automatic testMidReset();
    tallCell = 1'b0;
    doLine(1'b0, "mid");
    doLine(1'b0, "mid");
    doLine(1'b0, "mid");
    doReset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testResetState();
    testShortCell();
    testIdle();
    testOffMatrix();
    testTallCell();
    testRaiseTall();
    testDropTall();
    testMidReset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule